// File: doc/BRIEF.md
# CSR Access Execution Unit

This unit carries out the six control-and-status-register access instructions of a 32-bit core. These are swap, set-bits and clear-bits, each in a register-operand form and an immediate form. It receives a valid strobe with the instruction word and the value of the source register. In the same cycle it drives a simple CSR port with an address, a read strobe, a write strobe and the new value. The CSR side answers combinationally with the current contents and a mask of writable bits.

The strobes depend on which operand register or immediate field is named, not on the data value. A swap whose destination is x0 does not read. A set or clear whose source field is zero does not write. A swap always writes. A write aimed at a read-only CSR issues no strobe at all. Instead the access is reported as illegal. One cycle after an accepted instruction the unit reports completion, the destination-register write and the old CSR value, zero-extended to the register width.

Top module: `csr_exec_unit`

## Requirements
- R1: The instruction is split into CSR address [31:20], source field [19:15], funct3 [14:12], destination [11:7] and opcode [6:0]. The unit engages only when `in_valid` is high, the opcode is 7'b1110011 and funct3 is one of 001/101 (swap), 010/110 (set) or 011/111 (clear). Otherwise it drives no strobe and no `done`.
- R2: A swap writes the operand unchanged as `csr_wdata`. When the destination is not x0, the old CSR value is returned in `rd_value`.
- R3: A swap (register or immediate form) whose destination field is 0 drives no read strobe. Set and clear always read when they engage.
- R4: A set writes `old | (operand & csr_wmask)`, so bits with a clear mask bit keep their value.
- R5: A clear writes `old & ~(operand & csr_wmask)`, so bits with a clear mask bit keep their value.
- R6: A register-form set or clear whose source field [19:15] is 0 drives no write strobe and raises no fault, even on a read-only CSR.
- R7: A register-form set or clear whose source field is nonzero writes even when the register value is zero (`csr_wdata` equals the old value). It raises the fault if the CSR is read-only.
- R8: The immediate forms (funct3[2]=1) use bits [19:15] zero-extended as operand. A set-immediate or clear-immediate with a zero field does not write.
- R9: A CSR is read-only when address bits [11:10] are 2'b11. An attempted write to it drives neither strobe, sets `illegal` in the result cycle and suppresses the destination write.
- R10: `done`, `rd_we`, `rd_idx`, `rd_value` and `illegal` are registered and appear the cycle after the accepted instruction. `rd_we` is set only for a nonzero destination and with no fault. `rd_value` is the CSR value zero-extended to XLEN, and 0 when `rd_we` is low.
- R11: While `rst_n` is low at a clock edge, every registered output clears to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction presented this cycle |
| instr | input | 32 | Instruction word |
| rs1_val | input | XLEN | Value of the source register |
| csr_addr | output | 12 | CSR address |
| csr_rd_en | output | 1 | CSR read strobe |
| csr_wr_en | output | 1 | CSR write strobe |
| csr_wdata | output | CSR_W | New CSR value (0 when not writing) |
| csr_rdata | input | CSR_W | Current CSR value |
| csr_wmask | input | CSR_W | Writable-bit mask of the CSR |
| done | output | 1 | Access completed (registered) |
| rd_we | output | 1 | Destination register write enable |
| rd_idx | output | 5 | Destination register index |
| rd_value | output | XLEN | Old CSR value, zero-extended |
| illegal | output | 1 | Write to a read-only CSR attempted |

## Verification
The bench builds the unit with XLEN 32 and CSR_W 24. With this narrower CSR width, the zero-extension of `rd_value` is seen at the upper byte, and the truncation of wide register operands is exercised. The CSR model returns address-derived contents and a mask that depends on the address. This makes the unwritable bits in set and clear vary from one access to the next. Random addresses reach the read-only quarter of the address space often enough to hit the fault together with every operand form.

// File: rtl/csr_exec_pkg.sv
// Shared types and constants for the CSR access execution unit.
package csr_exec_pkg;

    localparam logic [6:0] OPC_SYSTEM = 7'b1110011;

    typedef enum logic [1:0] {
        CSR_OP_SWAP = 2'd0,
        CSR_OP_SET  = 2'd1,
        CSR_OP_CLR  = 2'd2,
        CSR_OP_NONE = 2'd3
    } csr_op_e;

endpackage

// File: rtl/csr_instr_decode.sv
// Splits the instruction word and decides engagement, read need and write attempt.
// Assumes the fixed CSR instruction layout; privilege is not considered.
module csr_instr_decode
    import csr_exec_pkg::*;
(
    input  logic        in_valid,
    input  logic [31:0] instr,
    output csr_op_e     op,
    output logic        use_imm,
    output logic        engaged,
    output logic        read_req,
    output logic        write_try,
    output logic        ro_target,
    output logic [4:0]  src_field,
    output logic [4:0]  dst_idx,
    output logic [11:0] addr
);

    logic [2:0] funct3;
    logic [6:0] opcode;

    assign addr      = instr[31:20];
    assign src_field = instr[19:15];
    assign funct3    = instr[14:12];
    assign dst_idx   = instr[11:7];
    assign opcode    = instr[6:0];
    assign use_imm   = funct3[2];

    // Map funct3 onto the operation kind.
    always_comb begin
        unique case (funct3)
            3'b001, 3'b101: op = CSR_OP_SWAP;
            3'b010, 3'b110: op = CSR_OP_SET;
            3'b011, 3'b111: op = CSR_OP_CLR;
            default:        op = CSR_OP_NONE;
        endcase
    end

    // Decide engagement and the field-based read/write gating.
    always_comb begin
        engaged   = in_valid && (opcode == OPC_SYSTEM) && (op != CSR_OP_NONE);
        read_req  = (op == CSR_OP_SWAP) ? (dst_idx != 5'd0) : 1'b1;
        write_try = (op == CSR_OP_SWAP) ? 1'b1 : (src_field != 5'd0);
        ro_target = (addr[11:10] == 2'b11);
    end

endmodule

// File: rtl/csr_wdata_calc.sv
// Forms the operand (register or zero-extended immediate) and the new CSR value.
// Swap writes the operand as is; set/clear only touch bits the mask marks writable.
module csr_wdata_calc
    import csr_exec_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int CSR_W = 32
) (
    input  csr_op_e          op,
    input  logic             use_imm,
    input  logic [4:0]       uimm,
    input  logic [XLEN-1:0]  rs1_val,
    input  logic [CSR_W-1:0] old_val,
    input  logic [CSR_W-1:0] wmask,
    output logic [CSR_W-1:0] new_val
);

    logic [CSR_W-1:0] operand;

    // Select the operand source.
    always_comb begin
        operand = '0;
        if (use_imm) operand[4:0] = uimm;
        else         operand      = rs1_val[CSR_W-1:0];
    end

    // Per-bit merge of operand into the old value.
    for (genvar b = 0; b < CSR_W; b++) begin : g_bit
        logic hit;
        assign hit = operand[b] & wmask[b];
        always_comb begin
            unique case (op)
                CSR_OP_SWAP: new_val[b] = operand[b];
                CSR_OP_SET:  new_val[b] = old_val[b] | hit;
                CSR_OP_CLR:  new_val[b] = old_val[b] & ~hit;
                default:     new_val[b] = old_val[b];
            endcase
        end
    end

endmodule

// File: rtl/csr_result_stage.sv
// Registers the completion, destination write and fault for one cycle.
// Assumes a synchronous active-low reset.
module csr_result_stage #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            accept,
    input  logic            fault,
    input  logic [4:0]      dst_idx,
    input  logic [XLEN-1:0] old_ext,
    output logic            done,
    output logic            rd_we,
    output logic [4:0]      rd_idx,
    output logic [XLEN-1:0] rd_value,
    output logic            illegal
);

    logic we_nxt;
    assign we_nxt = accept && !fault && (dst_idx != 5'd0);

    // Capture the result of the accepted access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            rd_we    <= 1'b0;
            rd_idx   <= 5'd0;
            rd_value <= '0;
            illegal  <= 1'b0;
        end else begin
            done     <= accept;
            rd_we    <= we_nxt;
            rd_idx   <= accept ? dst_idx : 5'd0;
            rd_value <= we_nxt ? old_ext : '0;
            illegal  <= accept && fault;
        end
    end

endmodule

// File: rtl/csr_exec_unit.sv
// Top of the CSR access execution unit: combinational CSR port, registered result.
// Assumes CSR_W <= XLEN and CSR_W >= 5; the CSR side answers in the same cycle.
module csr_exec_unit
    import csr_exec_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int CSR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [31:0]      instr,
    input  logic [XLEN-1:0]  rs1_val,
    output logic [11:0]      csr_addr,
    output logic             csr_rd_en,
    output logic             csr_wr_en,
    output logic [CSR_W-1:0] csr_wdata,
    input  logic [CSR_W-1:0] csr_rdata,
    input  logic [CSR_W-1:0] csr_wmask,
    output logic             done,
    output logic             rd_we,
    output logic [4:0]       rd_idx,
    output logic [XLEN-1:0]  rd_value,
    output logic             illegal
);

    csr_op_e          op;
    logic             use_imm, engaged, read_req, write_try, ro_target;
    logic [4:0]       src_field, dst_idx;
    logic             fault;
    logic [CSR_W-1:0] new_val;
    logic [XLEN-1:0]  old_ext;

    csr_instr_decode u_dec (
        .in_valid  (in_valid),
        .instr     (instr),
        .op        (op),
        .use_imm   (use_imm),
        .engaged   (engaged),
        .read_req  (read_req),
        .write_try (write_try),
        .ro_target (ro_target),
        .src_field (src_field),
        .dst_idx   (dst_idx),
        .addr      (csr_addr)
    );

    csr_wdata_calc #(.XLEN(XLEN), .CSR_W(CSR_W)) u_calc (
        .op      (op),
        .use_imm (use_imm),
        .uimm    (src_field),
        .rs1_val (rs1_val),
        .old_val (csr_rdata),
        .wmask   (csr_wmask),
        .new_val (new_val)
    );

    // Strobe gating: a faulting access touches the CSR not at all.
    always_comb begin
        fault     = engaged && write_try && ro_target;
        csr_rd_en = engaged && read_req && !fault;
        csr_wr_en = engaged && write_try && !fault;
        csr_wdata = csr_wr_en ? new_val : '0;
    end

    // Zero-extend the old CSR value to register width.
    always_comb begin
        old_ext              = '0;
        old_ext[CSR_W-1:0]   = csr_rdata;
    end

    csr_result_stage #(.XLEN(XLEN)) u_res (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (engaged),
        .fault    (fault),
        .dst_idx  (dst_idx),
        .old_ext  (old_ext),
        .done     (done),
        .rd_we    (rd_we),
        .rd_idx   (rd_idx),
        .rd_value (rd_value),
        .illegal  (illegal)
    );

endmodule

// File: rtl/csr_exec_checker.sv
// Port-level properties of the CSR access execution unit, bound to the top.
module csr_exec_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] instr,
    input logic [11:0] csr_addr,
    input logic        csr_rd_en,
    input logic        csr_wr_en,
    input logic        done,
    input logic        rd_we,
    input logic [4:0]  rd_idx,
    input logic        illegal
);

    logic sys_op;
    assign sys_op = in_valid && (instr[6:0] == 7'b1110011);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> (!csr_rd_en && !csr_wr_en));

    p_swap_x0_noread_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_op && instr[13:12] == 2'b01 && instr[11:7] == 5'd0) |-> !csr_rd_en);

    // R6 and R8: a zero source field on set/clear never writes.
    p_zero_field_nowrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_op && instr[13] && instr[19:15] == 5'd0) |-> !csr_wr_en);

    p_ro_never_written_r9: assert property (@(posedge clk) disable iff (!rst_n)
        csr_wr_en |-> (csr_addr[11:10] != 2'b11));

    p_fault_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> ($past(!csr_rd_en && !csr_wr_en) && !rd_we));

    p_done_after_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(in_valid));

    p_no_x0_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_we |-> (done && rd_idx != 5'd0));

endmodule

bind csr_exec_unit csr_exec_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .instr     (instr),
    .csr_addr  (csr_addr),
    .csr_rd_en (csr_rd_en),
    .csr_wr_en (csr_wr_en),
    .done      (done),
    .rd_we     (rd_we),
    .rd_idx    (rd_idx),
    .illegal   (illegal)
);

// File: tb/sim_csr_exec_unit.sv
module sim_csr_exec_unit;

    localparam int XLEN  = 32;
    localparam int CSR_W = 24;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [31:0]      instr = '0;
    logic [XLEN-1:0]  rs1_val = '0;
    logic [11:0]      csr_addr;
    logic             csr_rd_en, csr_wr_en;
    logic [CSR_W-1:0] csr_wdata, csr_rdata, csr_wmask;
    logic             done, rd_we, illegal;
    logic [4:0]       rd_idx;
    logic [XLEN-1:0]  rd_value;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    // CSR model: contents and writable mask derived from the address.
    function automatic logic [CSR_W-1:0] model_val(input logic [11:0] a);
        return {a, a ^ 12'hA5C};
    endfunction
    function automatic logic [CSR_W-1:0] model_mask(input logic [11:0] a);
        return ~(24'h00F0F0 << a[1:0]);
    endfunction

    assign csr_rdata = model_val(csr_addr);
    assign csr_wmask = model_mask(csr_addr);

    csr_exec_unit #(.XLEN(XLEN), .CSR_W(CSR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .rs1_val(rs1_val), .csr_addr(csr_addr), .csr_rd_en(csr_rd_en),
        .csr_wr_en(csr_wr_en), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .csr_wmask(csr_wmask), .done(done), .rd_we(rd_we), .rd_idx(rd_idx),
        .rd_value(rd_value), .illegal(illegal)
    );

    function automatic logic [31:0] mk(input logic [11:0] a, input logic [4:0] s,
                                       input logic [2:0] f3, input logic [4:0] d,
                                       input logic [6:0] opc);
        return {a, s, f3, d, opc};
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
        end
    endtask

    // Drive one instruction, check the CSR port, then the registered result.
    task automatic run_op(input logic [31:0] ins, input logic [31:0] rv, input string tag);
        logic [2:0] f3; logic [4:0] s, d; logic [11:0] a;
        logic eng, swp, wtry, rreq, flt, e_rd, e_wr, e_rdwe;
        logic [CSR_W-1:0] opnd, old, m, nv;
        logic [31:0] e_val;
        f3 = ins[14:12]; s = ins[19:15]; d = ins[11:7]; a = ins[31:20];
        eng  = (ins[6:0] == 7'b1110011) && f3[1:0] != 2'b00;
        swp  = f3[1:0] == 2'b01;
        wtry = swp ? 1'b1 : (s != 0);
        rreq = swp ? (d != 0) : 1'b1;
        flt  = eng && wtry && a[11:10] == 2'b11;
        e_rd = eng && rreq && !flt;
        e_wr = eng && wtry && !flt;
        opnd = f3[2] ? {19'd0, s} : rv[CSR_W-1:0];
        old = model_val(a); m = model_mask(a);
        if (swp)                nv = opnd;
        else if (f3[1:0] == 2)  nv = old | (opnd & m);
        else                    nv = old & ~(opnd & m);
        e_rdwe = eng && !flt && d != 0;
        e_val  = e_rdwe ? {8'd0, old} : 32'd0;

        @(negedge clk);
        instr = ins; rs1_val = rv; in_valid = 1'b1;
        #1;
        chk(tag, "csr_rd_en", {31'd0, csr_rd_en}, {31'd0, e_rd});
        chk(tag, "csr_wr_en", {31'd0, csr_wr_en}, {31'd0, e_wr});
        chk(tag, "csr_wdata", {8'd0, csr_wdata}, e_wr ? {8'd0, nv} : 32'd0);
        if (eng) chk(tag, "csr_addr", {20'd0, csr_addr}, {20'd0, a});
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        chk(tag, "done", {31'd0, done}, {31'd0, eng});
        chk(tag, "illegal", {31'd0, illegal}, {31'd0, flt});
        chk(tag, "rd_we", {31'd0, rd_we}, {31'd0, e_rdwe});
        chk(tag, "rd_value", rd_value, e_val);
        if (eng) chk(tag, "rd_idx", {27'd0, rd_idx}, {27'd0, d});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        seed = 32'd7;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        #1;
        // R11: reset state
        chk("R11", "done", {31'd0, done}, 32'd0);
        chk("R11", "rd_we", {31'd0, rd_we}, 32'd0);
        chk("R11", "illegal", {31'd0, illegal}, 32'd0);
        chk("R11", "rd_value", rd_value, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        run_op(mk(12'h340, 5'd5, 3'b001, 5'd3, 7'b1110011), 32'hFF12_3456, "R2 swap");
        run_op(mk(12'h341, 5'd9, 3'b101, 5'd0, 7'b1110011), 32'h0, "R3 swap-imm x0");
        run_op(mk(12'h342, 5'd7, 3'b001, 5'd0, 7'b1110011), 32'h55, "R3 swap x0");
        run_op(mk(12'h343, 5'd4, 3'b010, 5'd6, 7'b1110011), 32'hFFFF_FFFF, "R4 set");
        run_op(mk(12'h302, 5'd4, 3'b011, 5'd6, 7'b1110011), 32'hFFFF_FFFF, "R5 clear");
        run_op(mk(12'h344, 5'd0, 3'b010, 5'd2, 7'b1110011), 32'h1234, "R6 set x0");
        run_op(mk(12'hC01, 5'd0, 3'b011, 5'd2, 7'b1110011), 32'h1234, "R6 clear x0 ro");
        run_op(mk(12'h345, 5'd7, 3'b010, 5'd1, 7'b1110011), 32'h0, "R7 zero value");
        run_op(mk(12'hC00, 5'd7, 3'b011, 5'd1, 7'b1110011), 32'h0, "R7 zero value ro");
        run_op(mk(12'h346, 5'd0, 3'b110, 5'd8, 7'b1110011), 32'hFFFF_FFFF, "R8 set-imm zero");
        run_op(mk(12'h347, 5'd31, 3'b111, 5'd8, 7'b1110011), 32'hFFFF_FFFF, "R8 clear-imm");
        run_op(mk(12'h348, 5'd21, 3'b101, 5'd8, 7'b1110011), 32'hFFFF_FFFF, "R8 swap-imm");
        run_op(mk(12'hC80, 5'd3, 3'b001, 5'd9, 7'b1110011), 32'h77, "R9 swap ro");
        run_op(mk(12'hF11, 5'd3, 3'b110, 5'd9, 7'b1110011), 32'h0, "R9 set-imm ro");
        run_op(mk(12'h349, 5'd3, 3'b100, 5'd9, 7'b1110011), 32'h77, "R1 bad funct3");
        run_op(mk(12'h349, 5'd3, 3'b001, 5'd9, 7'b0110011), 32'h77, "R1 bad opcode");
        run_op(mk(12'h34A, 5'd3, 3'b010, 5'd0, 7'b1110011), 32'h8, "R10 set rd x0");

        for (int i = 0; i < 400; i++) begin
            logic [31:0] ins, rv;
            logic [6:0] opc;
            logic [4:0] s, d;
            opc = ($urandom % 8 == 0) ? 7'($urandom) : 7'b1110011;
            s = ($urandom % 4 == 0) ? 5'd0 : 5'($urandom);
            d = ($urandom % 4 == 0) ? 5'd0 : 5'($urandom);
            rv = ($urandom % 8 == 0) ? 32'd0 : $urandom;
            ins = mk(12'($urandom), s, 3'($urandom), d, opc);
            run_op(ins, rv, "R1 R2 R4 R5 R10 random");
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule